// File: doc/BRIEF.md
# Instruction-Block Address Range Comparator Bank

This block holds a bank of address range comparators for a processor trace unit. Value registers are taken two at a time, and each pair gives the lower and upper bound of one range. At every waypoint the block receives the first and last address of the instruction block that just retired, together with a one-bit security/privilege qualifier. Every range is then tested in two ways. The overlap test asks whether any part of the block falls inside the range. The containment test asks whether the whole block falls inside it.

Both results are registered at the waypoint strobe and held until the next strobe. The overlap results are the per-range event outputs. A registered trace-enable decision is formed from two programmable selection masks. The include mask selects ranges whose overlap switches tracing on, and the exclude mask selects ranges whose containment vetoes it. Configuration is written through a plain select/data/write-enable port. A trace-unit reset clears only the held results and leaves the configuration intact.

Top module: `addr_range_bank`

## Requirements
- R1: Select value 2r writes the lower bound of range r and select 2r+1 writes its upper bound (r counted from zero), so a write reaches exactly one range.
- R2: One cycle after a strobe, ev_hit[r] is 1 exactly when lower ≤ wp_end and upper > wp_start and the range's qualifier passes.
- R3: One cycle after a strobe, excl_hit[r] is 1 exactly when lower ≤ wp_start and upper > wp_end and the range's qualifier passes.
- R4: The access setting of a range uses bit 0 as check-enable and bit 1 as the required wp_sec value. When bit 0 is 1 and wp_sec differs from bit 1, both results of that range are 0. When bit 0 is 0, wp_sec is ignored.
- R5: ev_hit, excl_hit and trace_en change only on a clock edge where wp_valid is high, and they hold their values between strobes.
- R6: trace_en after a strobe equals (include mask is zero, or some include-selected range overlaps) and no exclude-selected range contains the block. Bit r of each mask selects range r.
- R7: Every range is evaluated at every strobe, whether or not either mask selects it.
- R8: While tu_rst_n is low, ev_hit, excl_hit and trace_en are 0.
- R9: tu_rst_n does not alter the bounds, access settings or masks.
- R10: Select map: 0..15 are bounds, 16+r is the access setting of range r in data bits 1:0, 24 is the include mask and 25 is the exclude mask, each in data bits 7:0. Writes to selects 26..31 change nothing.
- R11: A strobe in the same cycle as a configuration write is evaluated with the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| tu_rst_n | input | 1 | Trace-unit reset, active low, asynchronous; clears held results |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 5 | Configuration register select |
| wr_data | input | 32 | Configuration write data |
| wp_valid | input | 1 | Waypoint strobe |
| wp_start | input | 32 | First address of the executed block |
| wp_end | input | 32 | Last address of the executed block |
| wp_sec | input | 1 | Security/privilege state of the block |
| ev_hit | output | 8 | Held overlap result per range |
| excl_hit | output | 8 | Held containment result per range |
| trace_en | output | 1 | Held trace-enable decision |

## Verification
The bench drives blocks that touch each edge of a range. A block ending exactly on the lower bound must overlap. A block starting on the upper bound must not overlap. A block ending one below the upper bound is contained, and one ending on it is not. A design that swapped a strict and a non-strict compare would flip one of these. Qualifier mismatches, masks that select only some ranges, a write landing in the strobe cycle, writes to unused selects and a reset between strobes are all exercised. A block that forgot the veto, leaked new configuration into the current strobe, or lost bounds on reset would produce a wrong trace_en or hit vector.

// File: rtl/arc_pkg.sv
package arc_pkg;
   // bit 1: required security value, bit 0: check enable
   typedef struct packed {
      logic want;
      logic chk;
   } acc_t;
endpackage

// File: rtl/arc_cfg_regs.sv
module arc_cfg_regs #(
   parameter int ADDR_W   = 32,
   parameter int NUM_VALS = 16,
   parameter int NUM_RNG  = NUM_VALS / 2,
   parameter int SEL_W    = 5
) (
   input  logic                             clk,
   input  logic                             wr_en,
   input  logic [SEL_W-1:0]                 wr_sel,
   input  logic [ADDR_W-1:0]                wr_data,
   output logic [NUM_RNG-1:0][ADDR_W-1:0]   lo_q,
   output logic [NUM_RNG-1:0][ADDR_W-1:0]   hi_q,
   output arc_pkg::acc_t [NUM_RNG-1:0]      acc_q,
   output logic [NUM_RNG-1:0]               imask_q,
   output logic [NUM_RNG-1:0]               xmask_q
);
   localparam int SEL_ACC = NUM_VALS;
   localparam int SEL_IM  = NUM_VALS + NUM_RNG;
   localparam int SEL_XM  = NUM_VALS + NUM_RNG + 1;

   // configuration is deliberately not reset
   for (genvar r = 0; r < NUM_RNG; r++) begin : g_rng
      logic [ADDR_W-1:0] lo_r, hi_r;
      arc_pkg::acc_t     acc_r;
      always_ff @(posedge clk) begin
         if (wr_en && wr_sel == SEL_W'(2*r))       lo_r  <= wr_data;
         if (wr_en && wr_sel == SEL_W'(2*r+1))     hi_r  <= wr_data;
         if (wr_en && wr_sel == SEL_W'(SEL_ACC+r)) acc_r <= arc_pkg::acc_t'(wr_data[1:0]);
      end
      assign lo_q[r]  = lo_r;
      assign hi_q[r]  = hi_r;
      assign acc_q[r] = acc_r;
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_sel == SEL_W'(SEL_IM)) imask_q <= wr_data[NUM_RNG-1:0];
      if (wr_en && wr_sel == SEL_W'(SEL_XM)) xmask_q <= wr_data[NUM_RNG-1:0];
   end
endmodule

// File: rtl/arc_cmp.sv
module arc_cmp #(
   parameter int ADDR_W  = 32,
   parameter bit QUAL_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic [ADDR_W-1:0] blk_start,
   input  logic [ADDR_W-1:0] blk_end,
   input  logic              sec,
   input  arc_pkg::acc_t     acc,
   output logic              ovl,
   output logic              cont
);
   logic qual_ok;
   logic raw_ovl, raw_cont;

   assign raw_ovl  = (lo <= blk_end)   && (hi > blk_start);
   assign raw_cont = (lo <= blk_start) && (hi > blk_end);

   if (QUAL_EN) begin : g_qual
      assign qual_ok = !acc.chk || (sec == acc.want);
   end else begin : g_noqual
      logic unused_qual;
      assign unused_qual = ^{acc, sec};
      assign qual_ok     = 1'b1;
   end

   assign ovl  = raw_ovl  && qual_ok;
   assign cont = raw_cont && qual_ok;
endmodule

// File: rtl/arc_decide.sv
module arc_decide #(
   parameter int NUM_RNG = 8
) (
   input  logic [NUM_RNG-1:0] ovl,
   input  logic [NUM_RNG-1:0] cont,
   input  logic [NUM_RNG-1:0] imask,
   input  logic [NUM_RNG-1:0] xmask,
   output logic               te_next
);
   logic incl_ok, veto;
   always_comb begin
      incl_ok = (imask == '0) || ((imask & ovl) != '0);
      veto    = (xmask & cont) != '0;
      te_next = incl_ok && !veto;
   end
endmodule

// File: rtl/addr_range_bank.sv
module addr_range_bank #(
   parameter int ADDR_W   = 32,
   parameter int NUM_VALS = 16,
   parameter bit QUAL_EN  = 1'b1,
   localparam int NUM_RNG = NUM_VALS / 2,
   localparam int SEL_W   = $clog2(NUM_VALS + NUM_RNG + 2)
) (
   input  logic               clk,
   input  logic               tu_rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [ADDR_W-1:0]  wr_data,
   input  logic               wp_valid,
   input  logic [ADDR_W-1:0]  wp_start,
   input  logic [ADDR_W-1:0]  wp_end,
   input  logic               wp_sec,
   output logic [NUM_RNG-1:0] ev_hit,
   output logic [NUM_RNG-1:0] excl_hit,
   output logic               trace_en
);
   if (NUM_VALS < 2 || NUM_VALS > 16 || (NUM_VALS % 2) != 0) begin : g_bad_vals
      $error("NUM_VALS must be even and within 2..16");
   end
   if (ADDR_W < NUM_RNG || ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W too narrow for mask writes");
   end

   logic [NUM_RNG-1:0][ADDR_W-1:0] lo_q, hi_q;
   arc_pkg::acc_t [NUM_RNG-1:0]    acc_q;
   logic [NUM_RNG-1:0]             imask_q, xmask_q;
   logic [NUM_RNG-1:0]             ovl_v, cont_v;
   logic                           te_next;

   arc_cfg_regs #(
      .ADDR_W(ADDR_W), .NUM_VALS(NUM_VALS), .NUM_RNG(NUM_RNG), .SEL_W(SEL_W)
   ) u_cfg (
      .clk(clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .lo_q(lo_q), .hi_q(hi_q), .acc_q(acc_q),
      .imask_q(imask_q), .xmask_q(xmask_q)
   );

   for (genvar r = 0; r < NUM_RNG; r++) begin : g_cmp
      arc_cmp #(.ADDR_W(ADDR_W), .QUAL_EN(QUAL_EN)) u_cmp (
         .lo(lo_q[r]), .hi(hi_q[r]),
         .blk_start(wp_start), .blk_end(wp_end),
         .sec(wp_sec), .acc(acc_q[r]),
         .ovl(ovl_v[r]), .cont(cont_v[r])
      );
   end

   arc_decide #(.NUM_RNG(NUM_RNG)) u_dec (
      .ovl(ovl_v), .cont(cont_v), .imask(imask_q), .xmask(xmask_q),
      .te_next(te_next)
   );

   always_ff @(posedge clk or negedge tu_rst_n) begin
      if (!tu_rst_n) begin
         ev_hit   <= '0;
         excl_hit <= '0;
         trace_en <= 1'b0;
      end else if (wp_valid) begin
         ev_hit   <= ovl_v;
         excl_hit <= cont_v;
         trace_en <= te_next;
      end
   end
endmodule

// File: rtl/arc_bank_chk.sv
module arc_bank_chk #(
   parameter int ADDR_W  = 32,
   parameter int NUM_RNG = 8,
   parameter bit QUAL_EN = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wp_valid,
   input logic [ADDR_W-1:0]    wp_start,
   input logic [ADDR_W-1:0]    wp_end,
   input logic                 wp_sec,
   input logic [2*NUM_RNG-1:0] acc_flat,
   input logic [NUM_RNG-1:0]   xmask,
   input logic [NUM_RNG-1:0]   ev_hit,
   input logic [NUM_RNG-1:0]   excl_hit,
   input logic                 trace_en
);
   logic [NUM_RNG-1:0] blk;
   always_comb begin
      for (int r = 0; r < NUM_RNG; r++)
         blk[r] = QUAL_EN && acc_flat[2*r] && (acc_flat[2*r+1] != wp_sec);
   end

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_valid |=> ($stable(ev_hit) && $stable(excl_hit) && $stable(trace_en)))
      else $error("held outputs moved without a strobe");

   assert_cont_in_ovl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_valid && (wp_start <= wp_end)) |=> ((excl_hit & ~ev_hit) == '0))
      else $error("containment without overlap");

   assert_qual_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wp_valid |=> (((ev_hit | excl_hit) & $past(blk)) == '0))
      else $error("qualifier failure did not suppress match");

   assert_excl_veto_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wp_valid |=> !(trace_en && ((excl_hit & $past(xmask)) != '0)))
      else $error("trace enabled despite selected containment");

   assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |=> (ev_hit == '0 && excl_hit == '0 && !trace_en))
      else $error("held outputs not cleared by reset");
endmodule

bind addr_range_bank arc_bank_chk #(
   .ADDR_W(ADDR_W), .NUM_RNG(NUM_RNG), .QUAL_EN(QUAL_EN)
) u_chk (
   .clk(clk), .rst_n(tu_rst_n), .wp_valid(wp_valid),
   .wp_start(wp_start), .wp_end(wp_end), .wp_sec(wp_sec),
   .acc_flat(acc_q), .xmask(xmask_q),
   .ev_hit(ev_hit), .excl_hit(excl_hit), .trace_en(trace_en)
);

// File: tb/sim_addr_range_bank.sv
`timescale 1ns/1ps
module sim_addr_range_bank;
   localparam int NR = 8;

   logic        clk = 1'b0;
   logic        tu_rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        wp_valid = 1'b0;
   logic [31:0] wp_start = '0, wp_end = '0;
   logic        wp_sec = 1'b0;
   logic [NR-1:0] ev_hit, excl_hit;
   logic        trace_en;

   int n_tests = 0, n_fail = 0;
   bit cmp_on = 1'b0, done = 1'b0;

   always #2.5 clk = ~clk;

   addr_range_bank u0 (
      .clk(clk), .tu_rst_n(tu_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .wp_valid(wp_valid), .wp_start(wp_start),
      .wp_end(wp_end), .wp_sec(wp_sec), .ev_hit(ev_hit),
      .excl_hit(excl_hit), .trace_en(trace_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [31:0] m_lo [NR], m_hi [NR];
   logic [1:0]  m_acc [NR];
   logic [NR-1:0] m_im = '0, m_xm = '0;
   logic [NR-1:0] e_ev = '0, e_ex = '0;
   logic        e_te = 1'b0;

   initial for (int i = 0; i < NR; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_acc[i] = 0; end

   always @(posedge clk or negedge tu_rst_n) begin
      if (!tu_rst_n) begin
         e_ev = '0; e_ex = '0; e_te = 1'b0;
      end else if (wp_valid) begin
         logic any_inc, any_exc;
         any_inc = 1'b0; any_exc = 1'b0;
         for (int i = 0; i < NR; i++) begin
            bit q;
            q = !m_acc[i][0] || (m_acc[i][1] == wp_sec);
            e_ev[i] = q && (m_lo[i] <= wp_end) && (m_hi[i] > wp_start);
            e_ex[i] = q && (m_lo[i] <= wp_start) && (m_hi[i] > wp_end);
            if (m_im[i] && e_ev[i]) any_inc = 1'b1;
            if (m_xm[i] && e_ex[i]) any_exc = 1'b1;
         end
         e_te = (m_im == 0 || any_inc) && !any_exc;
      end
   end

   always @(posedge clk) begin
      if (wr_en) begin
         if (wr_sel < 16) begin
            if (wr_sel[0]) m_hi[wr_sel/2] <= wr_data;
            else           m_lo[wr_sel/2] <= wr_data;
         end else if (wr_sel < 24) m_acc[wr_sel-16] <= wr_data[1:0];
         else if (wr_sel == 24)    m_im <= wr_data[NR-1:0];
         else if (wr_sel == 25)    m_xm <= wr_data[NR-1:0];
      end
   end

   always @(negedge clk) if (cmp_on) begin
      chk("R2 overlap vs model", ev_hit, e_ev);
      chk("R3 containment vs model", excl_hit, e_ex);
      chk("R6 trace enable vs model", trace_en, e_te);
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input int sel, input logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = 5'(sel); wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic strobe(input logic [31:0] s, input logic [31:0] e, input logic sec);
      @(posedge clk); #1;
      wp_valid = 1'b1; wp_start = s; wp_end = e; wp_sec = sec;
      @(posedge clk); #1;
      wp_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R8 reset state", {ev_hit, excl_hit, 7'b0, trace_en}, 32'h0);
      #1 tu_rst_n = 1'b1;
      cmp_on = 1'b1;

      for (int r = 0; r < NR; r++) begin
         wr(2*r, 32'(r*100));
         wr(2*r+1, 32'(r*100 + 50));
         wr(16+r, 32'h0);
      end
      wr(24, 0); wr(25, 0);

      // R1: pair 2/3 forms range 1
      strobe(120, 130, 0);
      chk("R1 pairing ev", ev_hit, 8'h02);
      chk("R1 pairing ex", excl_hit, 8'h02);
      chk("R6 empty include mask", trace_en, 1);

      // boundaries on range 1 [100,150)
      strobe(90, 100, 0);
      chk("R2 end on lower bound", ev_hit, 8'h02);
      chk("R3 start below lower bound", excl_hit, 8'h00);
      strobe(150, 160, 0);
      chk("R2 start on upper bound", ev_hit, 8'h00);
      strobe(100, 149, 0);
      chk("R3 contained at edges", excl_hit, 8'h02);
      strobe(100, 150, 0);
      chk("R3 end on upper bound", excl_hit, 8'h00);
      chk("R2 end on upper bound overlaps", ev_hit, 8'h02);

      // R4 qualifier
      wr(17, 32'h3);
      strobe(120, 130, 0);
      chk("R4 qualifier mismatch", {ev_hit, excl_hit}, 16'h0000);
      strobe(120, 130, 1);
      chk("R4 qualifier match", {ev_hit, excl_hit}, 16'h0202);
      wr(17, 32'h2);
      strobe(120, 130, 0);
      chk("R4 check disabled ignores sec", ev_hit, 8'h02);
      wr(17, 32'h0);

      // R6 / R7 masks
      wr(24, 32'h04);
      strobe(120, 130, 0);
      chk("R6 include miss", trace_en, 0);
      chk("R7 unselected range evaluated", ev_hit, 8'h02);
      strobe(210, 220, 0);
      chk("R6 include hit", trace_en, 1);
      wr(25, 32'h04);
      strobe(210, 220, 0);
      chk("R6 exclude veto", trace_en, 0);
      strobe(190, 210, 0);
      chk("R6 partial overlap not vetoed", trace_en, 1);

      // R5 hold
      @(posedge clk); #1;
      wp_start = 10; wp_end = 20;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R5 hold between strobes", {ev_hit, 7'b0, trace_en}, {8'h04, 8'h01});

      // R8 / R9 reset
      @(posedge clk); #1 tu_rst_n = 1'b0;
      @(negedge clk);
      chk("R8 reset clears", {ev_hit, excl_hit, 7'b0, trace_en}, 32'h0);
      @(posedge clk); #1 tu_rst_n = 1'b1;
      strobe(210, 220, 0);
      chk("R9 config kept ev", {ev_hit, excl_hit}, 16'h0404);
      chk("R9 masks kept", trace_en, 0);

      // R10 unused selects
      wr(26, 32'hFFFF_FFFF);
      wr(31, 32'h0);
      strobe(190, 210, 0);
      chk("R10 unused select ignored", {ev_hit, 7'b0, trace_en}, {8'h04, 8'h01});

      // R11 write coinciding with strobe
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = 5'd25; wr_data = 0;
      wp_valid = 1'b1; wp_start = 210; wp_end = 220; wp_sec = 0;
      @(posedge clk); #1;
      wr_en = 1'b0; wp_valid = 1'b0;
      @(negedge clk);
      chk("R11 strobe uses old mask", trace_en, 0);
      strobe(210, 220, 0);
      chk("R11 new mask after write", trace_en, 1);

      // random phase against the model
      for (int k = 0; k < 4000; k++) begin
         @(posedge clk); #1;
         tu_rst_n = ($urandom_range(0, 149) != 0);
         wr_en    = tu_rst_n && ($urandom_range(0, 3) == 0);
         wr_sel   = 5'($urandom_range(0, 31));
         wr_data  = 32'($urandom_range(0, 511));
         wp_valid = ($urandom_range(0, 1) == 1);
         wp_start = 32'($urandom_range(0, 511));
         wp_end   = wp_start + 32'($urandom_range(0, 60));
         wp_sec   = 1'($urandom_range(0, 1));
      end
      @(posedge clk); #1;
      tu_rst_n = 1'b1; wr_en = 1'b0; wp_valid = 1'b0;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule